// File: doc/BRIEF.md
# Packet Receive Deframer with Dual-Seed CRC Check

This block sits behind a demodulator and turns a stream of symbol decisions into stored packet payload. On each symbol strobe it receives one data bit, a flag that says whether the symbol correlated, and a flag that says whether the symbol matched the start code. It finds the start of a packet and captures the length byte. It writes payload bytes into a small first-in first-out receive buffer and checks the two trailing check bytes against a CRC16 that is computed in two forms, once from a programmable seed and once from zero.

A packet can end in two ways. In length mode it ends after the number of bytes given in the length byte, plus two check bytes when checking is on. In the other mode it ends after a programmable run of symbols that failed to correlate. At the end of a packet the block pulses a completion interrupt and updates the check and validity status. When automatic acknowledge is enabled, it also requests an acknowledge for every valid packet. The host drains the buffer through a read strobe. For packets longer than the buffer, the host must drain during reception, and a half-level interrupt tells it when to do so.

Top module: `rx_deframer`

## Requirements
- R1: When `cfg_framing_en`=1, a packet starts on two consecutive symbol strobes that both have `sym_sop`=1. When `cfg_framing_en`=0, it starts on two consecutive strobes that both have `sym_corr`=1. Cycles without a strobe do not break the pair, and an intervening strobe without the flag does.
- R2: Data bits arrive most significant bit first. In length mode the first byte after the start goes to `rx_len` and is not stored. The payload bytes that follow are read back from the buffer in arrival order.
- R3: In length mode the packet ends after `rx_len` payload bytes, plus two check bytes when `cfg_crc_en`=1. `irq_done` pulses for one cycle in the cycle after the last symbol, with `busy` low.
- R4: The check value is a CRC16 with polynomial x^16+x^15+x^2+1 (0x8005), left-shifting and MSB first, run over the payload bits only. The received 16-bit value arrives MSB first. `crc_ok` is set at the end of the packet when that value equals the CRC started from `cfg_seed` or the CRC started from zero. `crc_ok` is 0 when checking is disabled or in non-correlation mode.
- R5: In length mode, `pkt_valid` at the end of the packet is 1 when no overflow occurred and either checking is disabled or `crc_ok` is 1.
- R6: With `cfg_len_en`=0 there is no length byte. Symbols with `sym_corr`=0 carry no data. The packet ends on the `cfg_nc_limit`-th consecutive uncorrelated symbol, and a partial byte is dropped. `pkt_valid` is then 1 when no overflow occurred.
- R7: The buffer holds DEPTH (16) bytes and presents its oldest byte on `rd_data`. `rd_en` removes that byte, and `rd_en` has no effect on an empty buffer. `buf_count` gives the fill level.
- R8: A payload byte arriving at a full buffer is dropped and sets `overflow`. The flag stays set until the next start of packet, and that packet ends with `pkt_valid`=0.
- R9: `irq_half` pulses for one cycle when a write raises the fill level to DEPTH/2 (8).
- R10: `ack_req` pulses together with `irq_done` exactly when `cfg_autoack_en`=1 and the packet is valid.
- R11: While a packet is being received, start-code symbols are taken as ordinary data and do not restart reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_vld | input | 1 | Symbol strobe |
| sym_bit | input | 1 | Data bit of the symbol |
| sym_corr | input | 1 | Symbol correlated |
| sym_sop | input | 1 | Symbol matched the start code |
| cfg_framing_en | input | 1 | Start on start-code pair (1) or on correlation pair (0) |
| cfg_len_en | input | 1 | Length-byte ending (1) or non-correlation ending (0) |
| cfg_crc_en | input | 1 | Two check bytes follow the payload |
| cfg_autoack_en | input | 1 | Request acknowledge for valid packets |
| cfg_seed | input | 16 | Programmable CRC seed |
| cfg_nc_limit | input | NCW | Uncorrelated-symbol run that ends a packet |
| rd_en | input | 1 | Remove oldest buffered byte |
| rd_data | output | 8 | Oldest buffered byte |
| buf_count | output | CW | Buffer fill level |
| busy | output | 1 | Packet reception in progress |
| rx_len | output | 8 | Last captured length byte |
| crc_ok | output | 1 | Check matched on the last packet |
| pkt_valid | output | 1 | Last packet valid |
| overflow | output | 1 | Sticky buffer overflow |
| irq_done | output | 1 | End-of-packet pulse |
| irq_half | output | 1 | Half-level pulse |
| ack_req | output | 1 | Acknowledge request pulse |

## Verification
One packet is sent with the check computed from zero while the seed is non-zero. A design that compares against only one CRC would reject it, and another would accept a corrupted check value. A zero-length packet checks that the check bytes follow straight after the length byte, and a 16-byte packet fills the buffer exactly. An 18-byte undrained packet checks that the surplus bytes are dropped rather than written over the oldest ones, and that the flag survives the end of the packet. A start-code symbol inside the payload and a broken start pair catch a detector that is armed during reception or that counts start symbols that are not consecutive. In non-correlation mode, uncorrelated symbols are placed mid-stream and before the terminating run, which exposes a counter that fails to reset or that stores non-data symbols.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive deframer.
// Assumes: nothing beyond IEEE 1800-2017.
package rxd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEN  = 2'd1,
        ST_BODY = 2'd2,
        ST_CRC  = 2'd3
    } rx_state_e;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h8005;
endpackage

// File: rtl/rxd_sop_detect.sv
// Start-of-packet detector: flags a start when two consecutive symbol
// strobes both carry the selected hit flag (start code or correlation).
// Assumes: armed is high only while the deframer is idle; history is
// cleared whenever the detector is disarmed.
module rxd_sop_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic framing_en,
    input  logic sym_vld,
    input  logic sym_corr,
    input  logic sym_sop,
    output logic sop
);
    logic hit;
    logic hit_q;

    // Select which flag counts as a start symbol.
    always_comb hit = framing_en ? sym_sop : sym_corr;

    // Start fires on the second consecutive hit while armed.
    always_comb sop = armed && sym_vld && hit && hit_q;

    // Remember whether the previous strobe was a hit.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) hit_q <= 1'b0;
        else if (sym_vld)     hit_q <= hit;
    end
endmodule

// File: rtl/rxd_crc16.sv
// Serial CRC register, MSB first, left shifting.
// Assumes: init and en are never high together for a meaningful bit.
module rxd_crc16 #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h8005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic [W-1:0] seed,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] nxt;

    // Next value for one incoming bit.
    always_comb begin
        fb  = bit_in ^ crc[W-1];
        nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end

    // Load the seed at packet start, then advance per data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= '0;
        else if (init) crc <= seed;
        else if (en)   crc <= nxt;
    end
endmodule

// File: rtl/rxd_fifo.sv
// Receive byte buffer, first-word fall-through, with half-level pulse.
// Assumes: writes to a full buffer are dropped (caller flags it);
// reads from an empty buffer are ignored.
module rxd_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          half_pulse
);
    localparam int HALF = DEPTH / 2;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    // Accept handshakes only when they can succeed.
    always_comb begin
        full  = (count == CW'(DEPTH));
        do_wr = wr_en && !full;
        do_rd = rd_en && (count != '0);
    end

    assign rd_data = mem[rd_ptr];

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointer, level and half-level pulse bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            half_pulse <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
            half_pulse <= do_wr && !do_rd && (count == CW'(HALF - 1));
        end
    end
endmodule

// File: rtl/rx_deframer.sv
// Packet receive deframer: start detection, length capture, payload
// buffering, dual-seed CRC16 check, end by length or by a run of
// uncorrelated symbols, completion/half interrupts and ack request.
// Assumes: configuration is static while busy; one symbol per strobe.
module rx_deframer
    import rxd_pkg::*;
#(
    parameter int  DEPTH = 16,
    parameter int  NCW   = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sym_vld,
    input  logic           sym_bit,
    input  logic           sym_corr,
    input  logic           sym_sop,
    input  logic           cfg_framing_en,
    input  logic           cfg_len_en,
    input  logic           cfg_crc_en,
    input  logic           cfg_autoack_en,
    input  logic [15:0]    cfg_seed,
    input  logic [NCW-1:0] cfg_nc_limit,
    input  logic           rd_en,
    output logic [7:0]     rd_data,
    output logic [CW-1:0]  buf_count,
    output logic           busy,
    output logic [7:0]     rx_len,
    output logic           crc_ok,
    output logic           pkt_valid,
    output logic           overflow,
    output logic           irq_done,
    output logic           irq_half,
    output logic           ack_req
);
    rx_state_e        state_q;
    logic [2:0]       bitcnt_q;
    logic [7:0]       shreg_q, remain_q, crc_hi_q;
    logic             crc_byte_q;
    logic [NCW-1:0]   nc_cnt_q;
    logic [NCW:0]     nc_next;
    logic             sop, take, byte_done, wr_byte, buf_full, ovf_now;
    logic             nc_hit, nc_end, len_end, crc_end, pkt_end, match, valid_now;
    logic [7:0]       new_byte;
    logic [CRC_W-1:0] crc_v [2];

    rxd_sop_detect u_sop (
        .clk(clk), .rst_n(rst_n), .armed(state_q == ST_IDLE),
        .framing_en(cfg_framing_en), .sym_vld(sym_vld),
        .sym_corr(sym_corr), .sym_sop(sym_sop), .sop(sop)
    );

    // Two CRC registers: index 0 uses the programmed seed, 1 uses zero.
    for (genvar g = 0; g < 2; g++) begin : g_crc
        rxd_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
            .clk(clk), .rst_n(rst_n), .init(sop),
            .seed((g == 0) ? cfg_seed : 16'h0000),
            .en(take && state_q == ST_BODY), .bit_in(sym_bit),
            .crc(crc_v[g])
        );
    end

    rxd_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_byte), .wr_data(new_byte),
        .rd_en(rd_en), .rd_data(rd_data), .count(buf_count),
        .full(buf_full), .half_pulse(irq_half)
    );

    // Symbol qualification, byte assembly and end-of-packet decode.
    always_comb begin
        take      = sym_vld && (state_q != ST_IDLE) && (cfg_len_en || sym_corr);
        byte_done = take && (bitcnt_q == 3'd7);
        new_byte  = {shreg_q[6:0], sym_bit};
        wr_byte   = byte_done && (state_q == ST_BODY);
        ovf_now   = wr_byte && buf_full;
        nc_hit    = sym_vld && (state_q == ST_BODY) && !cfg_len_en && !sym_corr;
        nc_next   = {1'b0, nc_cnt_q} + 1'b1;
        nc_end    = nc_hit && (nc_next >= {1'b0, cfg_nc_limit});
        len_end   = !cfg_crc_en && byte_done &&
                    (((state_q == ST_BODY) && cfg_len_en && (remain_q == 8'd1)) ||
                     ((state_q == ST_LEN) && (new_byte == 8'd0)));
        crc_end   = (state_q == ST_CRC) && byte_done && crc_byte_q;
        pkt_end   = len_end || crc_end || nc_end;
        match     = ({crc_hi_q, new_byte} == crc_v[0]) ||
                    ({crc_hi_q, new_byte} == crc_v[1]);
        valid_now = !(overflow || ovf_now) &&
                    (!cfg_len_en || !cfg_crc_en || (crc_end && match));
    end

    assign busy = (state_q != ST_IDLE);

    // Reception state machine and per-packet counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            remain_q   <= '0;
            crc_hi_q   <= '0;
            crc_byte_q <= 1'b0;
            nc_cnt_q   <= '0;
            rx_len     <= '0;
        end else begin
            if (take) begin
                bitcnt_q <= bitcnt_q + 1'b1;
                shreg_q  <= new_byte;
            end
            if (nc_hit)                      nc_cnt_q <= nc_next[NCW-1:0];
            else if (sym_vld && sym_corr)    nc_cnt_q <= '0;
            unique case (state_q)
                ST_IDLE: if (sop) begin
                    state_q    <= cfg_len_en ? ST_LEN : ST_BODY;
                    bitcnt_q   <= '0;
                    nc_cnt_q   <= '0;
                    crc_byte_q <= 1'b0;
                end
                ST_LEN: if (byte_done) begin
                    rx_len   <= new_byte;
                    remain_q <= new_byte;
                    if (new_byte != 8'd0) state_q <= ST_BODY;
                    else                  state_q <= cfg_crc_en ? ST_CRC : ST_IDLE;
                end
                ST_BODY: begin
                    if (cfg_len_en && byte_done) begin
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == 8'd1) state_q <= cfg_crc_en ? ST_CRC : ST_IDLE;
                    end
                    if (nc_end) state_q <= ST_IDLE;
                end
                ST_CRC: if (byte_done) begin
                    crc_hi_q   <= new_byte;
                    crc_byte_q <= 1'b1;
                    if (crc_byte_q) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status, sticky overflow and end-of-packet pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_ok    <= 1'b0;
            pkt_valid <= 1'b0;
            overflow  <= 1'b0;
            irq_done  <= 1'b0;
            ack_req   <= 1'b0;
        end else begin
            irq_done <= pkt_end;
            ack_req  <= pkt_end && valid_now && cfg_autoack_en;
            if (sop)          overflow <= 1'b0;
            else if (ovf_now) overflow <= 1'b1;
            if (pkt_end) begin
                crc_ok    <= crc_end && match;
                pkt_valid <= valid_now;
            end
        end
    end
endmodule

// File: rtl/rx_deframer_chk.sv
// Checker for rx_deframer: temporal properties on its ports.
// Assumes: bound to every rx_deframer instance.
module rx_deframer_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [CW-1:0] buf_count,
    input logic          busy,
    input logic          pkt_valid,
    input logic          overflow,
    input logic          irq_done,
    input logic          irq_half,
    input logic          ack_req
);
    localparam int HALF = DEPTH / 2;

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !busy);
    a_r10_ack_with_valid_done: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (irq_done && pkt_valid));
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !busy) |=> (overflow || busy));
    a_r8_overflow_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && overflow) |-> !pkt_valid);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= CW'(DEPTH));
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && buf_count == '0) |=> (buf_count <= CW'(1)));
    a_r9_half_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half |-> (buf_count == CW'(HALF)));
endmodule

bind rx_deframer rx_deframer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .buf_count(buf_count),
    .busy(busy), .pkt_valid(pkt_valid), .overflow(overflow),
    .irq_done(irq_done), .irq_half(irq_half), .ack_req(ack_req)
);

// File: tb/rx_deframer_bench.sv
// Self-checking bench: table of packets, then directed corner cases.
module rx_deframer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int NCW   = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic sym_vld = 0, sym_bit = 0, sym_corr = 0, sym_sop = 0;
    logic cfg_framing_en = 1, cfg_len_en = 1, cfg_crc_en = 1, cfg_autoack_en = 1;
    logic [15:0] cfg_seed = 16'hFFFF;
    logic [NCW-1:0] cfg_nc_limit = 4'd3;
    logic rd_en = 0;
    logic [7:0] rd_data, rx_len;
    logic [CW-1:0] buf_count;
    logic busy, crc_ok, pkt_valid, overflow, irq_done, irq_half, ack_req;

    int n_chk = 0, n_bad = 0;
    int n_done = 0, n_ack = 0, n_half = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_deframer #(.DEPTH(DEPTH), .NCW(NCW)) u_rx_deframer (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_bit(sym_bit),
        .sym_corr(sym_corr), .sym_sop(sym_sop), .cfg_framing_en(cfg_framing_en),
        .cfg_len_en(cfg_len_en), .cfg_crc_en(cfg_crc_en),
        .cfg_autoack_en(cfg_autoack_en), .cfg_seed(cfg_seed),
        .cfg_nc_limit(cfg_nc_limit), .rd_en(rd_en), .rd_data(rd_data),
        .buf_count(buf_count), .busy(busy), .rx_len(rx_len), .crc_ok(crc_ok),
        .pkt_valid(pkt_valid), .overflow(overflow), .irq_done(irq_done),
        .irq_half(irq_half), .ack_req(ack_req)
    );

    // Pulse monitors on the output ports.
    always @(posedge clk) begin
        if (irq_done) n_done++;
        if (ack_req)  n_ack++;
        if (irq_half) n_half++;
    end

    typedef struct packed {
        logic       framing;
        logic       crc_en;
        logic       zero_seed;
        logic       corrupt;
        logic       autoack;
        logic [15:0] seed;
        logic [7:0] len;
        logic [7:0] base;
        logic [7:0] step;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 8'd4,  8'h11, 8'h22},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF, 8'd5,  8'h80, 8'h07},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, 8'd3,  8'h3C, 8'h01},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd6,  8'hF0, 8'h13},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1234, 8'd0,  8'h00, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA5A5, 8'd16, 8'h05, 8'h11}
    };

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic fb;
        for (int k = 7; k >= 0; k--) begin
            fb = b[k] ^ c[15];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sym(input logic b, input logic c, input logic s);
        @(negedge clk);
        sym_vld = 1; sym_bit = b; sym_corr = c; sym_sop = s;
        @(negedge clk);
        sym_vld = 0; sym_bit = 0; sym_corr = 0; sym_sop = 0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic s);
        for (int k = 7; k >= 0; k--) sym(v[k], 1'b1, s);
    endtask

    task automatic start_pair();
        for (int k = 0; k < 3; k++) sym(1'b0, 1'b0, 1'b0);
        sym(1'b1, 1'b1, cfg_framing_en);
        sym(1'b0, 1'b1, cfg_framing_en);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic read_byte(input string tag, input logic [7:0] exp);
        check(tag, rd_data, exp);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pl [48];
        logic [15:0] c;
        int d0, a0, h0;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // Reset state (R7, R8, R3)
        check("R7 reset count", buf_count, 0);
        check("R3 reset busy", busy, 0);
        check("R8 reset overflow", overflow, 0);
        check("R5 reset valid", pkt_valid, 0);
        check("R4 reset crc_ok", crc_ok, 0);

        // Empty read ignored (R7)
        rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
        check("R7 empty read", buf_count, 0);

        // Table of packets (R1..R5, R9, R10)
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            cfg_framing_en = t.framing; cfg_len_en = 1; cfg_crc_en = t.crc_en;
            cfg_autoack_en = t.autoack; cfg_seed = t.seed;
            c = t.zero_seed ? 16'h0000 : t.seed;
            for (int i = 0; i < int'(t.len); i++) begin
                pl[i] = t.base + 8'(i) * t.step;
                c = crc_byte(c, pl[i]);
            end
            if (t.corrupt) c = c ^ 16'h0001;
            d0 = n_done; a0 = n_ack; h0 = n_half;
            start_pair();
            send_byte(t.len, 1'b0);
            for (int i = 0; i < int'(t.len); i++) send_byte(pl[i], 1'b0);
            if (t.crc_en) begin send_byte(c[15:8], 1'b0); send_byte(c[7:0], 1'b0); end
            idle(3);
            check($sformatf("R1 R3 v%0d done count", v), n_done - d0, 1);
            check($sformatf("R3 v%0d busy", v), busy, 0);
            check($sformatf("R2 v%0d length", v), rx_len, t.len);
            check($sformatf("R4 v%0d crc_ok", v), crc_ok, t.crc_en && !t.corrupt);
            check($sformatf("R5 v%0d valid", v), pkt_valid, !(t.crc_en && t.corrupt));
            check($sformatf("R10 v%0d ack", v), n_ack - a0,
                  (t.autoack && !(t.crc_en && t.corrupt)) ? 1 : 0);
            check($sformatf("R9 v%0d half", v), n_half - h0, (t.len >= 8) ? 1 : 0);
            check($sformatf("R7 v%0d fill", v), buf_count, t.len);
            for (int i = 0; i < int'(t.len); i++)
                read_byte($sformatf("R2 v%0d byte%0d", v, i), pl[i]);
            check($sformatf("R7 v%0d drained", v), buf_count, 0);
        end

        // Broken start pair does not start (R1)
        cfg_framing_en = 1;
        sym(1'b0, 1'b0, 1'b0); sym(1'b1, 1'b1, 1'b1); sym(1'b1, 1'b1, 1'b0);
        sym(1'b1, 1'b1, 1'b1); sym(1'b0, 1'b0, 1'b0);
        idle(2);
        check("R1 no start on split pair", busy, 0);

        // Start code inside payload is data (R11)
        cfg_crc_en = 0; cfg_autoack_en = 0; d0 = n_done;
        start_pair();
        send_byte(8'd2, 1'b0);
        send_byte(8'hC3, 1'b1);
        send_byte(8'h5A, 1'b1);
        idle(3);
        check("R11 single end", n_done - d0, 1);
        check("R11 fill", buf_count, 2);
        read_byte("R11 byte0", 8'hC3);
        read_byte("R11 byte1", 8'h5A);

        // Overflow with undrained 18-byte packet (R8)
        cfg_crc_en = 1; cfg_autoack_en = 1; cfg_seed = 16'hFFFF;
        c = 16'hFFFF;
        for (int i = 0; i < 18; i++) begin pl[i] = 8'(i * 9 + 1); c = crc_byte(c, pl[i]); end
        a0 = n_ack;
        start_pair();
        send_byte(8'd18, 1'b0);
        for (int i = 0; i < 18; i++) send_byte(pl[i], 1'b0);
        send_byte(c[15:8], 1'b0); send_byte(c[7:0], 1'b0);
        idle(3);
        check("R8 overflow set", overflow, 1);
        check("R8 invalid", pkt_valid, 0);
        check("R8 crc still ok", crc_ok, 1);
        check("R10 no ack on overflow", n_ack - a0, 0);
        check("R8 fill at depth", buf_count, DEPTH);
        idle(4);
        check("R8 overflow held", overflow, 1);
        for (int i = 0; i < 16; i++) read_byte($sformatf("R8 kept byte%0d", i), pl[i]);

        // Next packet clears overflow (R8)
        cfg_crc_en = 0;
        start_pair();
        send_byte(8'd1, 1'b0);
        send_byte(8'h77, 1'b0);
        idle(3);
        check("R8 overflow cleared", overflow, 0);
        check("R5 valid after clear", pkt_valid, 1);
        read_byte("R2 single byte", 8'h77);

        // Non-correlation ending (R6)
        cfg_len_en = 0; cfg_nc_limit = 4'd3; cfg_crc_en = 0; d0 = n_done;
        start_pair();
        send_byte(8'hA1, 1'b0);
        sym(1'b1, 1'b0, 1'b0); sym(1'b1, 1'b0, 1'b0);
        send_byte(8'h2B, 1'b0);
        sym(1'b1, 1'b1, 1'b0); sym(1'b0, 1'b1, 1'b0); sym(1'b1, 1'b1, 1'b0);
        sym(1'b0, 1'b0, 1'b0); sym(1'b0, 1'b0, 1'b0);
        idle(2);
        check("R6 not ended early", busy, 1);
        sym(1'b0, 1'b0, 1'b0);
        idle(3);
        check("R6 ended", n_done - d0, 1);
        check("R6 valid", pkt_valid, 1);
        check("R6 crc_ok", crc_ok, 0);
        check("R6 partial dropped", buf_count, 2);
        read_byte("R6 byte0", 8'hA1);
        read_byte("R6 byte1", 8'h2B);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule